// File: doc/BRIEF.md
# Byte-Mask Write-Merging Line Buffer

This block is a small, fully associative write-back buffer between a store source and a memory controller. It gathers partial stores into whole lines without first fetching those lines from memory. Each store carries a byte address, one data word and a per-byte enable. A store that misses claims a free entry straight away. A store that hits is merged into the entry that already holds its line. Each entry tracks exactly which of its bytes have been written.

Lines leave the buffer as block writes. Each block write carries the line address, every data byte of the line and a per-byte mask, and the receiver updates only the masked bytes. A line is written out in two cases: when every entry is in use and a store needs a new one, or when a flush command drains the whole buffer. Because no line is fetched and only the written bytes are marked, stores from several writers to different bytes of one line all reach memory intact.

Top module: `bytemask_merge_buf`

## Requirements
- R1: After reset the buffer is empty: `wb_valid` is 0, `st_ready` is 1 and `flush_ready` is 1.
- R2: A store whose line is absent, accepted while fewer than ENTRIES lines are held, claims an entry with no memory traffic: `wb_valid` stays 0.
- R3: Writeback byte k of the line is `wb_data[8k+7:8k]`, and its mask bit is `wb_mask[k]`. A store to word w (byte address bits [OFF_W-1:LANE_W]) with enable bit j targets line byte w*WORD_BYTES+j. A hit replaces only the enabled bytes, and ORs their bits into the line mask.
- R4: When two stores write the same byte, the one accepted later supplies that byte's value at writeback.
- R5: Stores to different bytes of one line are all retained, and all appear in the single writeback of that line.
- R6: In a writeback, every byte whose mask bit is 0 carries data 0.
- R7: When all entries are in use and a store misses, the least recently allocated line is written back first. `st_ready` stays 0 until that writeback is accepted. A hit does not change allocation order.
- R8: While `wb_valid` is 1 and `wb_ready` is 0, `wb_valid`, `wb_addr`, `wb_data` and `wb_mask` hold their values.
- R9: A flush accepted with `flush_valid` and `flush_ready` both 1 writes back every held line, oldest first. `flush_ready` and `st_ready` are 0 until the drain ends. A flush of an empty buffer produces no writeback.
- R10: Once a line's writeback is accepted its entry is free. A later store to that address starts a fresh line whose mask holds only the newly written bytes.
- R11: When `flush_valid` and `st_valid` are both high in an idle cycle, the flush is taken first. The store is accepted only after the drain, and lands in the emptied buffer.
- R12: A store with an all-zero byte enable is accepted and changes nothing. It allocates no entry and causes no eviction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store request present |
| st_ready | output | 1 | Store accepted this cycle when high with `st_valid` |
| st_addr | input | ADDR_W | Store byte address (low LANE_W bits ignored) |
| st_data | input | WORD_BYTES*8 | Store data word |
| st_be | input | WORD_BYTES | Store byte enables |
| flush_valid | input | 1 | Flush request |
| flush_ready | output | 1 | Flush accepted this cycle when high with `flush_valid` |
| wb_valid | output | 1 | Block write present |
| wb_ready | input | 1 | Memory side accepts the block write |
| wb_addr | output | ADDR_W | Line-aligned byte address of the block write |
| wb_data | output | LINE_BYTES*8 | All data bytes of the line |
| wb_mask | output | LINE_BYTES | One bit per byte that memory must update |

## Verification
Three kinds of store sequence go into a single line:
- partial enables that are spread across words, which separate a merge that ORs the mask from one that overwrites it;
- overlapping enables, which show whether the later store wins;
- disjoint single bytes, which show whether bytes from separate writers are kept.

A fill-past-capacity run, with a hit placed between the evictions, tells true allocation-order eviction apart from recency order. Re-storing an evicted address tells a freed entry apart from a stale mask. Flush runs cover three cases: an empty buffer, a flush that coincides with a store, and a drain under periodic memory backpressure, which exercises the hold of a stalled block write.

// File: rtl/wmb_pkg.sv
package wmb_pkg;
  typedef enum logic [1:0] {
    WMB_IDLE  = 2'd0,
    WMB_EVICT = 2'd1,
    WMB_FLUSH = 2'd2
  } wmb_state_e;
endpackage

// File: rtl/wmb_tag_cam.sv
module wmb_tag_cam #(
  parameter int ENTRIES = 4,
  parameter int TAG_W   = 26,
  parameter int IDX_W   = 2
) (
  input  logic [ENTRIES-1:0]       occ,
  input  logic [ENTRIES*TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]         look_tag,
  output logic                     hit,
  output logic [IDX_W-1:0]         hit_idx
);
  logic [ENTRIES-1:0] match;

  genvar gi;
  generate
    for (gi = 0; gi < ENTRIES; gi++) begin : g_cmp
      assign match[gi] = occ[gi] && (tags[gi*TAG_W +: TAG_W] == look_tag);
    end
  endgenerate

  always_comb begin
    hit     = |match;
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) hit_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/wmb_lines.sv
module wmb_lines #(
  parameter int ENTRIES    = 4,
  parameter int IDX_W      = 2,
  parameter int TAG_W      = 26,
  parameter int LINE_BYTES = 64,
  parameter int WORD_BYTES = 8,
  parameter int WSEL_W     = 3
) (
  input  logic                       clk,
  input  logic                       we,
  input  logic                       clear,
  input  logic [IDX_W-1:0]           widx,
  input  logic [TAG_W-1:0]           wtag,
  input  logic [WSEL_W-1:0]          wsel,
  input  logic [WORD_BYTES*8-1:0]    wdata,
  input  logic [WORD_BYTES-1:0]      wbe,
  input  logic [IDX_W-1:0]           ridx,
  output logic [ENTRIES*TAG_W-1:0]   tags_flat,
  output logic [TAG_W-1:0]           rd_tag,
  output logic [LINE_BYTES*8-1:0]    rd_data,
  output logic [LINE_BYTES-1:0]      rd_mask
);
  localparam int LINE_BITS = LINE_BYTES * 8;

  logic [LINE_BITS-1:0]  data_q [ENTRIES];
  logic [LINE_BYTES-1:0] mask_q [ENTRIES];
  logic [TAG_W-1:0]      tag_q  [ENTRIES];

  logic [LINE_BITS-1:0]  wr_line;
  logic [LINE_BYTES-1:0] wr_bmask;
  logic [LINE_BITS-1:0]  old_data;
  logic [LINE_BITS-1:0]  new_data;
  logic [LINE_BYTES-1:0] new_mask;

  // Spread the incoming word over its lane of the line
  genvar gb;
  generate
    for (gb = 0; gb < LINE_BYTES; gb++) begin : g_lane
      localparam int WI = gb / WORD_BYTES;
      localparam int LI = gb % WORD_BYTES;
      assign wr_bmask[gb]       = (wsel == WSEL_W'(WI)) && wbe[LI];
      assign wr_line[8*gb +: 8] = wdata[8*LI +: 8];
    end
  endgenerate

  assign old_data = data_q[widx];

  always_comb begin
    new_mask = clear ? wr_bmask : (mask_q[widx] | wr_bmask);
    for (int b = 0; b < LINE_BYTES; b++) begin
      if (wr_bmask[b])  new_data[8*b +: 8] = wr_line[8*b +: 8];
      else if (clear)   new_data[8*b +: 8] = 8'h00;
      else              new_data[8*b +: 8] = old_data[8*b +: 8];
    end
  end

  // Datapath storage: written only under enable, occupancy tracked elsewhere
  always_ff @(posedge clk) begin
    if (we) begin
      data_q[widx] <= new_data;
      mask_q[widx] <= new_mask;
      if (clear) tag_q[widx] <= wtag;
    end
  end

  genvar ge;
  generate
    for (ge = 0; ge < ENTRIES; ge++) begin : g_tags
      assign tags_flat[ge*TAG_W +: TAG_W] = tag_q[ge];
    end
  endgenerate

  assign rd_tag  = tag_q[ridx];
  assign rd_data = data_q[ridx];
  assign rd_mask = mask_q[ridx];
endmodule

// File: rtl/wmb_ctrl.sv
module wmb_ctrl
  import wmb_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int IDX_W   = 2,
  parameter int CNT_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               st_valid,
  input  logic               st_nz,
  input  logic               hit,
  input  logic               flush_valid,
  input  logic               wb_ready,
  output logic               st_ready,
  output logic               flush_ready,
  output logic               wb_valid,
  output logic               alloc_we,
  output logic               merge_we,
  output logic [IDX_W-1:0]   head,
  output logic [IDX_W-1:0]   tail,
  output logic [ENTRIES-1:0] occ
);
  wmb_state_e       state_q, state_d;
  logic [IDX_W-1:0] head_q, head_d, tail_q, tail_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             full, st_fire, wb_fire;

  assign full = (cnt_q == CNT_W'(ENTRIES));

  // An entry is occupied when it lies within cnt entries from the head
  genvar gi;
  generate
    for (gi = 0; gi < ENTRIES; gi++) begin : g_occ
      logic [IDX_W-1:0] rel;
      assign rel     = IDX_W'(gi) - head_q;
      assign occ[gi] = CNT_W'(rel) < cnt_q;
    end
  endgenerate

  always_comb begin
    flush_ready = (state_q == WMB_IDLE);
    st_ready    = (state_q == WMB_IDLE) && !flush_valid && (hit || !full || !st_nz);
    wb_valid    = (state_q != WMB_IDLE) && (cnt_q != '0);
    st_fire     = st_valid && st_ready;
    alloc_we    = st_fire && st_nz && !hit;
    merge_we    = st_fire && st_nz && hit;
    wb_fire     = wb_valid && wb_ready;

    state_d = state_q;
    head_d  = head_q;
    tail_d  = tail_q;
    cnt_d   = cnt_q;

    unique case (state_q)
      WMB_IDLE: begin
        if (flush_valid)                           state_d = WMB_FLUSH;
        else if (st_valid && st_nz && !hit && full) state_d = WMB_EVICT;
      end
      WMB_EVICT: if (wb_fire)        state_d = WMB_IDLE;
      WMB_FLUSH: if (cnt_q == '0)    state_d = WMB_IDLE;
      default:                       state_d = WMB_IDLE;
    endcase

    if (alloc_we) begin
      tail_d = tail_q + 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
    if (wb_fire) begin
      head_d = head_q + 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WMB_IDLE;
      head_q  <= '0;
      tail_q  <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      head_q  <= head_d;
      tail_q  <= tail_d;
      cnt_q   <= cnt_d;
    end
  end

  assign head = head_q;
  assign tail = tail_q;
endmodule

// File: rtl/bytemask_merge_buf.sv
module bytemask_merge_buf #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int WORD_BYTES = 8,
  parameter int ENTRIES    = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    st_valid,
  output logic                    st_ready,
  input  logic [ADDR_W-1:0]       st_addr,
  input  logic [WORD_BYTES*8-1:0] st_data,
  input  logic [WORD_BYTES-1:0]   st_be,
  input  logic                    flush_valid,
  output logic                    flush_ready,
  output logic                    wb_valid,
  input  logic                    wb_ready,
  output logic [ADDR_W-1:0]       wb_addr,
  output logic [LINE_BYTES*8-1:0] wb_data,
  output logic [LINE_BYTES-1:0]   wb_mask
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int LANE_W = $clog2(WORD_BYTES);
  localparam int WSEL_W = OFF_W - LANE_W;
  localparam int TAG_W  = ADDR_W - OFF_W;
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int CNT_W  = $clog2(ENTRIES + 1);

  logic [TAG_W-1:0]         st_tag, head_tag;
  logic [WSEL_W-1:0]        st_wsel;
  logic                     st_nz, hit, alloc_we, merge_we;
  logic [IDX_W-1:0]         hit_idx, head, tail, widx;
  logic [ENTRIES-1:0]       occ;
  logic [ENTRIES*TAG_W-1:0] tags_flat;
  logic                     unused_lane;

  assign st_tag      = st_addr[ADDR_W-1:OFF_W];
  assign st_wsel     = st_addr[OFF_W-1:LANE_W];
  assign unused_lane = ^st_addr[LANE_W-1:0];
  assign st_nz       = |st_be;
  assign widx        = alloc_we ? tail : hit_idx;

  wmb_tag_cam #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_cam (
    .occ      (occ),
    .tags     (tags_flat),
    .look_tag (st_tag),
    .hit      (hit),
    .hit_idx  (hit_idx)
  );

  wmb_ctrl #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .st_valid    (st_valid),
    .st_nz       (st_nz),
    .hit         (hit),
    .flush_valid (flush_valid),
    .wb_ready    (wb_ready),
    .st_ready    (st_ready),
    .flush_ready (flush_ready),
    .wb_valid    (wb_valid),
    .alloc_we    (alloc_we),
    .merge_we    (merge_we),
    .head        (head),
    .tail        (tail),
    .occ         (occ)
  );

  wmb_lines #(
    .ENTRIES(ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W),
    .LINE_BYTES(LINE_BYTES), .WORD_BYTES(WORD_BYTES), .WSEL_W(WSEL_W)
  ) u_lines (
    .clk       (clk),
    .we        (alloc_we || merge_we),
    .clear     (alloc_we),
    .widx      (widx),
    .wtag      (st_tag),
    .wsel      (st_wsel),
    .wdata     (st_data),
    .wbe       (st_be),
    .ridx      (head),
    .tags_flat (tags_flat),
    .rd_tag    (head_tag),
    .rd_data   (wb_data),
    .rd_mask   (wb_mask)
  );

  assign wb_addr = {head_tag, {OFF_W{1'b0}}};
endmodule

// File: rtl/wmb_checker.sv
module wmb_checker #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    st_ready,
  input logic                    flush_valid,
  input logic                    flush_ready,
  input logic                    wb_valid,
  input logic                    wb_ready,
  input logic [ADDR_W-1:0]       wb_addr,
  input logic [LINE_BYTES*8-1:0] wb_data,
  input logic [LINE_BYTES-1:0]   wb_mask
);
  logic [LINE_BYTES*8-1:0] keep;

  genvar gb;
  generate
    for (gb = 0; gb < LINE_BYTES; gb++) begin : g_keep
      assign keep[8*gb +: 8] = {8{wb_mask[gb]}};
    end
  endgenerate

  AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_addr) && $stable(wb_data) && $stable(wb_mask)); // R8
  AST_STORE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> !st_ready && !flush_ready); // R7
  AST_WB_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> wb_mask != '0); // R12
  AST_CLEAN_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_data & ~keep) == '0); // R6
  AST_FLUSH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid && flush_ready |=> !flush_ready); // R9
  AST_FLUSH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid && flush_ready |-> !st_ready); // R11
endmodule

bind bytemask_merge_buf wmb_checker #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_wmb_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .st_ready    (st_ready),
  .flush_valid (flush_valid),
  .flush_ready (flush_ready),
  .wb_valid    (wb_valid),
  .wb_ready    (wb_ready),
  .wb_addr     (wb_addr),
  .wb_data     (wb_data),
  .wb_mask     (wb_mask)
);

// File: tb/tb_bytemask_merge_buf.sv
module tb_bytemask_merge_buf;
  localparam int AW = 32, LB = 64, WB = 8, NE = 4, OFFW = 6, TAGW = AW - OFFW;

  logic clk = 1'b0;
  logic rst_n;
  always #2 clk = ~clk;

  logic st_valid, st_ready, flush_valid, flush_ready, wb_valid, wb_ready;
  logic [AW-1:0]   st_addr, wb_addr;
  logic [WB*8-1:0] st_data;
  logic [WB-1:0]   st_be;
  logic [LB*8-1:0] wb_data;
  logic [LB-1:0]   wb_mask;

  bytemask_merge_buf #(.ADDR_W(AW), .LINE_BYTES(LB), .WORD_BYTES(WB), .ENTRIES(NE)) dut (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
    .st_data(st_data), .st_be(st_be), .flush_valid(flush_valid), .flush_ready(flush_ready),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr), .wb_data(wb_data), .wb_mask(wb_mask)
  );

  typedef struct packed {
    logic [TAGW-1:0] tag;
    logic [LB*8-1:0] data;
    logic [LB-1:0]   mask;
  } line_t;

  line_t model[$];
  line_t expq[$];
  string expr[$];
  int checks = 0, fails = 0;
  bit bp = 1'b0;
  int cyc = 0;

  task automatic chk(bit ok, string req, logic [LB*8-1:0] act, logic [LB*8-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int find_line(logic [TAGW-1:0] t);
    for (int i = 0; i < model.size(); i++) if (model[i].tag == t) return i;
    return -1;
  endfunction

  function automatic logic [AW-1:0] line_addr(int n);
    return 32'h0000_1000 + AW'(n) * 32'd64;
  endfunction

  function automatic logic [WB*8-1:0] pat(int n);
    return {32'(n) * 32'h0101_0101 ^ 32'hA5A5_0000, 32'(n) + 32'h0000_1234};
  endfunction

  // Memory side: periodic backpressure when bp is set
  always @(posedge clk) begin
    #1;
    wb_ready = bp ? (cyc % 3 == 2) : 1'b1;
    cyc++;
  end

  // Driver: updates the reference model, queues expected writebacks, drives one store
  task automatic do_store(logic [AW-1:0] a, logic [WB*8-1:0] d, logic [WB-1:0] be, string req);
    logic [TAGW-1:0] t;
    int w, idx;
    bit evict, first;
    line_t l;
    t = a[AW-1:OFFW];
    w = int'(a[OFFW-1:3]);
    evict = 1'b0;
    if (be != '0) begin
      idx = find_line(t);
      if (idx < 0 && model.size() == NE) begin
        expq.push_back(model.pop_front());
        expr.push_back("R7 oldest evicted");
        evict = 1'b1;
      end
      if (idx < 0) begin
        l = '0; l.tag = t;
      end else l = model[idx];
      for (int j = 0; j < WB; j++) if (be[j]) begin
        l.data[(w*WB+j)*8 +: 8] = d[j*8 +: 8];
        l.mask[w*WB+j] = 1'b1;
      end
      if (idx < 0) model.push_back(l); else model[idx] = l;
    end
    @(posedge clk); #1;
    st_valid = 1'b1; st_addr = a; st_data = d; st_be = be;
    first = 1'b1;
    do begin
      @(negedge clk);
      if (first && evict) chk(!st_ready, "R7 stall on full miss", LB*8'(st_ready), '0);
      first = 1'b0;
    end while (!st_ready);
    if (!evict) chk(!wb_valid, {req, " no writeback on store"}, LB*8'(wb_valid), '0);
    @(posedge clk); #1;
    st_valid = 1'b0;
  endtask

  task automatic queue_all(string req);
    while (model.size() > 0) begin
      expq.push_back(model.pop_front());
      expr.push_back(req);
    end
  endtask

  task automatic wait_drain(string req);
    do @(negedge clk); while (!flush_ready);
    repeat (4) @(negedge clk);
    chk(expq.size() == 0, {req, " all expected writebacks seen"}, LB*8'(expq.size()), '0);
  endtask

  task automatic do_flush(string req);
    queue_all(req);
    @(posedge clk); #1;
    flush_valid = 1'b1;
    do @(negedge clk); while (!flush_ready);
    @(posedge clk); #1;
    flush_valid = 1'b0;
    @(negedge clk);
    chk(!flush_ready, "R9 flush_ready low while draining", LB*8'(flush_ready), '0);
    wait_drain(req);
  endtask

  // Monitor: compares each accepted writeback with the scoreboard front
  bit hold_pend = 1'b0;
  logic [AW-1:0] h_addr; logic [LB*8-1:0] h_data; logic [LB-1:0] h_mask;
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (hold_pend)
          chk(wb_valid && wb_addr == h_addr && wb_data == h_data && wb_mask == h_mask,
              "R8 stalled writeback held", wb_data, h_data);
        hold_pend = 1'b0;
        if (wb_valid && !wb_ready) begin
          hold_pend = 1'b1; h_addr = wb_addr; h_data = wb_data; h_mask = wb_mask;
        end
        if (wb_valid && wb_ready) begin
          if (expq.size() == 0) begin
            chk(1'b0, "R10 unexpected writeback", LB*8'(wb_addr), '0);
          end else begin
            line_t e; string r;
            e = expq.pop_front(); r = expr.pop_front();
            chk(wb_addr == {e.tag, 6'd0}, {r, " addr"}, LB*8'(wb_addr), LB*8'({e.tag, 6'd0}));
            chk(wb_mask == e.mask, {r, " mask"}, LB*8'(wb_mask), LB*8'(e.mask));
            chk(wb_data == e.data, {r, " data"}, wb_data, e.data);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; st_valid = 1'b0; flush_valid = 1'b0; wb_ready = 1'b1;
    st_addr = '0; st_data = '0; st_be = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!wb_valid, "R1 wb_valid after reset", LB*8'(wb_valid), '0);
    chk(st_ready, "R1 st_ready after reset", LB*8'(st_ready), 1);
    chk(flush_ready, "R1 flush_ready after reset", LB*8'(flush_ready), 1);

    // R9: flush of empty buffer yields nothing
    do_flush("R9 empty flush");

    // R3: merges across and within words
    do_store(line_addr(0) + 0,  pat(1), 8'h0F, "R2");
    do_store(line_addr(0) + 0,  pat(2), 8'hF0, "R3");
    do_store(line_addr(0) + 24, pat(3), 8'hFF, "R3");
    do_store(line_addr(0) + 56, pat(4), 8'h81, "R3");
    do_flush("R3 merged line");

    // R4: later wins; R5: disjoint writers kept
    do_store(line_addr(1) + 8,  pat(5), 8'hFF, "R4");
    do_store(line_addr(1) + 8,  pat(6), 8'h3C, "R4");
    do_store(line_addr(2) + 16, pat(7), 8'h01, "R5");
    do_store(line_addr(2) + 16, pat(8), 8'h80, "R5");
    do_store(line_addr(2) + 40, pat(9), 8'h10, "R5");
    do_flush("R4 R5 lines");

    // R7: capacity eviction in allocation order, hit does not reorder
    for (int n = 10; n < 14; n++) do_store(line_addr(n), pat(n), 8'hFF, "R2");
    do_store(line_addr(14), pat(14), 8'h0F, "R7");
    do_store(line_addr(11) + 8, pat(15), 8'hFF, "R7");
    do_store(line_addr(15), pat(16), 8'hF0, "R7");
    // R10: evicted line restarts with a fresh mask
    do_store(line_addr(10) + 32, pat(17), 8'h02, "R10");
    do_flush("R10 fresh line");

    // R12: zero enable store has no effect
    do_store(line_addr(20), pat(18), 8'h00, "R12");
    do_store(line_addr(21), pat(19), 8'h11, "R12");
    do_flush("R12 only written line");

    // R8: eviction and drain under backpressure
    bp = 1'b1;
    for (int n = 30; n < 36; n++) do_store(line_addr(n) + 8*(n % 8), pat(n), 8'h5A, "R8");
    do_flush("R8 drain under backpressure");
    bp = 1'b0;

    // R11: flush and store together, flush first
    do_store(line_addr(40), pat(40), 8'hFF, "R11");
    queue_all("R11 flush before store");
    begin
      line_t l;
      l = '0; l.tag = line_addr(41) >> OFFW;
      l.data[63:0] = pat(41); l.mask[7:0] = 8'hFF;
      model.push_back(l);
    end
    @(posedge clk); #1;
    flush_valid = 1'b1; st_valid = 1'b1; st_addr = line_addr(41); st_data = pat(41); st_be = 8'hFF;
    @(negedge clk);
    chk(!st_ready && flush_ready, "R11 flush taken before store", LB*8'(st_ready), '0);
    @(posedge clk); #1;
    flush_valid = 1'b0;
    do @(negedge clk); while (!st_ready);
    @(posedge clk); #1;
    st_valid = 1'b0;
    do_flush("R11 store after flush");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule